// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands of equal width and returns the full double-width product in the same cycle. It has no clock and no state. Every bit of the partial-product grid is a two-input AND of one multiplicand bit and one multiplier bit. The grid is summed by rows of three-input full-adder cells.

No row ripples carries along itself. Each cell passes its carry down a diagonal to a cell in the next row, where that carry meets a partial-product bit of the same weight. One row of cells at the bottom resolves the saved sums and carries, and this row produces the upper half of the product. The longest path is about 2N-1 full-adder delays. A grid that rippled within every row would take about 3N-4.

The operand width is a parameter. Its default is 8, and the design also elaborates at a width of 4. The block is meant to sit inside a larger datapath, with registers placed by the surrounding logic.

Top module: `csaMultiplier`

## Requirements
- R1: `product` equals the unsigned arithmetic product of `mcand` and `mplier` for every pair of operand values, as a 2N-bit result.
- R2: `product[0]` equals the AND of `mcand[0]` and `mplier[0]`, and no adder cell sits on this bit.
- R3: The final merge row never produces a carry beyond bit 2N-1, including when both operands are all ones (result (2^N-1)^2).
- R4: When either operand is zero, `product` is zero.
- R5: A multiplier of 1 returns the multiplicand zero-extended to 2N bits, and a multiplicand of 1 returns the multiplier zero-extended.
- R6: A multiplier of 2^k, for k from 0 to N-1, returns the multiplicand shifted left by k bits.
- R7: Swapping the two operands leaves `product` unchanged.
- R8: The width parameter N defaults to 8, and at N=4 the block meets R1 for all 256 operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | N | Unsigned multiplicand |
| mplier | input | N | Unsigned multiplier |
| product | output | 2N | Unsigned product |

## Verification
A diagonal carry saved in an upper row and the ripple carry in the merge row can reach the same final cell together. The merge row must then absorb both without losing one. Operands with long runs of ones provoke this, and all ones on both inputs is the worst case. Every result is judged against a shift-and-add model computed in the bench, and the carry out of the merge row is watched so that it stays zero.

// File: rtl/csaPkg.sv
package csaPkg;
  // Output pair of one full-adder cell
  typedef struct packed {
    logic sum;
    logic carry;
  } faOutT;
endpackage

// File: rtl/csaFullAdder.sv
module csaFullAdder
  import csaPkg::*;
(
  input  logic  x,
  input  logic  y,
  input  logic  z,
  output faOutT res
);
  logic halfSum;
  assign halfSum   = x ^ y;
  assign res.sum   = halfSum ^ z;
  assign res.carry = (x & y) | (z & halfSum);
endmodule

// File: rtl/csaPartialGen.sv
module csaPartialGen #(
  parameter int N = 8
) (
  input  logic [N-1:0]         mcand,
  input  logic [N-1:0]         mplier,
  output logic [N-1:0][N-1:0]  ppGrid
);
  // ppGrid[r][j] has weight r+j
  for (genvar r = 0; r < N; r++) begin : rowGen
    for (genvar j = 0; j < N; j++) begin : colGen
      assign ppGrid[r][j] = mcand[j] & mplier[r];
    end
  end
endmodule

// File: rtl/csaArray.sv
module csaArray
  import csaPkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0][N-1:0] ppGrid,
  output logic [2*N-1:0]      product,
  output logic                spill
);
  localparam int LAST = N - 1;

  // Row r keeps sums of weight r+j and carries of weight r+j+1
  for (genvar r = 0; r < N; r++) begin : rowGen
    logic [N:0]   rowSum;
    logic [N-1:0] rowCarry;
    if (r == 0) begin : seedRow
      assign rowSum   = {1'b0, ppGrid[0]};
      assign rowCarry = '0;
    end else begin : addRow
      faOutT cellOut [N];
      for (genvar j = 0; j < N; j++) begin : cellGen
        csaFullAdder uCell (
          .x   (ppGrid[r][j]),
          .y   (rowGen[r-1].rowSum[j+1]),
          .z   (rowGen[r-1].rowCarry[j]),
          .res (cellOut[j])
        );
        assign rowSum[j]   = cellOut[j].sum;
        assign rowCarry[j] = cellOut[j].carry;
      end
      assign rowSum[N] = 1'b0;
    end
    assign product[r] = rowSum[0];
  end

  // Merge row: a single ripple over weights N .. 2N-1
  logic [N:0] rippleC;
  faOutT      mergeOut [N];
  assign rippleC[0] = 1'b0;
  for (genvar k = 0; k < N; k++) begin : mergeGen
    csaFullAdder uMerge (
      .x   (rowGen[LAST].rowSum[k+1]),
      .y   (rowGen[LAST].rowCarry[k]),
      .z   (rippleC[k]),
      .res (mergeOut[k])
    );
    assign product[N+k] = mergeOut[k].sum;
    assign rippleC[k+1] = mergeOut[k].carry;
  end
  assign spill = rippleC[N];
endmodule

// File: rtl/csaMultiplier.sv
module csaMultiplier #(
  parameter int N = 8
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product
);
  logic [N-1:0][N-1:0] ppGrid;
  logic                spillBit;

  csaPartialGen #(.N(N)) uGen (
    .mcand  (mcand),
    .mplier (mplier),
    .ppGrid (ppGrid)
  );

  csaArray #(.N(N)) uArr (
    .ppGrid  (ppGrid),
    .product (product),
    .spill   (spillBit)
  );
endmodule

// File: rtl/csaMultiplierChk.sv
module csaMultiplierChk #(
  parameter int N = 8
) (
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic [2*N-1:0] product,
  input logic           spill
);
  localparam int W = 2 * N;
  logic [W-1:0] wideA, wideB;
  assign wideA = {{N{1'b0}}, mcand};
  assign wideB = {{N{1'b0}}, mplier};

  always_comb begin
    AST_NO_OVERFLOW: assert (spill == 1'b0) else $error("merge carry out set"); // R3
    AST_LSB_AND: assert (product[0] == (mcand[0] & mplier[0])) else $error("lsb mismatch"); // R2
    AST_ZERO_OPERAND: assert (!((mcand == '0) || (mplier == '0)) || (product == '0)) else $error("zero operand"); // R4
    AST_UNIT_MPLIER: assert (!(mplier == N'(1)) || (product == wideA)) else $error("unit multiplier"); // R5
    AST_REF_MATCH: assert (product == W'(wideA * wideB)) else $error("product mismatch"); // R1
  end
endmodule

bind csaMultiplier csaMultiplierChk #(.N(N)) uChk (
  .mcand   (mcand),
  .mplier  (mplier),
  .product (product),
  .spill   (spillBit)
);

// File: tb/sim_csaMultiplier.sv
module sim_csaMultiplier;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]  aWide = '0, bWide = '0;
  logic [15:0] pWide;
  logic [3:0]  aNar = '0, bNar = '0;
  logic [7:0]  pNar;

  csaMultiplier u0 (.mcand(aWide), .mplier(bWide), .product(pWide));
  csaMultiplier #(.N(4)) uSmall (.mcand(aNar), .mplier(bNar), .product(pNar));

  function automatic logic [15:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc = '0;
    for (int i = 0; i < 8; i++)
      if (b[i]) acc = acc + ({8'd0, a} << i);
    return acc;
  endfunction

  task automatic judge(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runWide(input logic [7:0] a, input logic [7:0] b, input string tag);
    @(posedge clk);
    aWide = a; bWide = b;
    @(negedge clk);
    judge(pWide, refMul(a, b), tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    judge(pWide, 16'd0, "R4 reset-state zero");
    rstN = 1'b1;

    // Directed corners
    runWide(8'd0, 8'd173, "R4 zero multiplicand");
    runWide(8'd91, 8'd0, "R4 zero multiplier");
    runWide(8'd255, 8'd255, "R3 all ones");
    runWide(8'd200, 8'd1, "R5 unit multiplier");
    runWide(8'd1, 8'd77, "R5 unit multiplicand");
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      aWide = 8'hB5; bWide = 8'd1 << k;
      @(negedge clk);
      judge(pWide, 16'hB5 << k, "R6 power-of-two shift");
    end
    runWide(8'hAA, 8'h55, "R1 alternating bits");
    runWide(8'h80, 8'h80, "R1 top bits only");

    // Random operands, with LSB and swap checks
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] a, b;
      logic [15:0] first;
      a = 8'($urandom);
      b = 8'($urandom);
      runWide(a, b, "R1 random pair");
      first = pWide;
      judge({15'd0, pWide[0]}, {15'd0, a[0] & b[0]}, "R2 lsb is and");
      runWide(b, a, "R1 random swapped");
      judge(pWide, first, "R7 swap invariance");
    end

    // Exhaustive at N=4
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(posedge clk);
        aNar = 4'(a); bNar = 4'(b);
        @(negedge clk);
        judge({8'd0, pNar}, refMul(8'(a), 8'(b)), "R8 narrow exhaustive");
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule